// File: doc/BRIEF.md
# PSK Hard-Decision Symbol Encoder

This block turns demodulated baseband samples into coded symbols. Each clock cycle it can accept one signed 16-bit in-phase/quadrature pair. It finds the angle of that pair with a fully pipelined CORDIC in vectoring mode, which has one stage per iteration. It then cuts the phase circle into 2, 4 or 8 equal sectors and sends the sector number through a table of codes that software can load.

Each ideal constellation point sits at the centre of its own sector, so the decision boundaries lie halfway between neighbouring points. The sector number is a raw index of 1 to 3 bits. That index selects a 3-bit field of the 24-bit code table. This lets the system apply any bit labelling (Gray, natural or a custom scheme) without changing the hardware. The modulation order and the table are captured together with each sample, so both can change on any cycle.

Top module: `psk_sym_decide`

## Requirements
- R1: The phase of each sample is computed from its signed 16-bit I/Q values with a 16-bit phase word in which 65536 counts equal one full turn. Angle 0 lies on the positive I axis and angles grow toward the positive Q axis.
- R2: When `mod_sel` = 2'b00 (two-phase), raw index 0 covers angles from -90 to +90 degrees and index 1 covers the opposite half plane. The index never exceeds 1.
- R3: When `mod_sel` = 2'b01 (four-phase), index k covers the 90-degree sector centred on k*90 degrees, for k = 0 to 3. The index never exceeds 3.
- R4: When `mod_sel` = 2'b10 (eight-phase), index k covers the 45-degree sector centred on k*45 degrees, for k = 0 to 7.
- R5: `mod_sel` = 2'b11 behaves exactly like eight-phase.
- R6: The output symbol is `code_tbl[3*idx+2 : 3*idx]`, where idx is the raw index. Entry 0 sits in bits 2:0 and entry 7 sits in bits 23:21.
- R7: A sample with I = 0 and Q = 0 yields raw index 0, so its symbol is `code_tbl[2:0]`, whatever the order selected.
- R8: `sym_valid` rises exactly 16 clock cycles after the edge that captures a sample with `smp_valid` high. One sample can be accepted on every cycle, and results come out in input order.
- R9: `sym_code` is 3'b000 in every cycle in which `sym_valid` is low.
- R10: `mod_sel` and `code_tbl` are sampled on the same edge as the sample. Changing them afterwards does not alter that sample's symbol.
- R11: An active-low reset discards every sample in flight. No symbol from before the reset appears after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Input sample qualifier |
| smp_i | input | 16 | In-phase sample, two's complement |
| smp_q | input | 16 | Quadrature sample, two's complement |
| mod_sel | input | 2 | Constellation order: 00 two, 01 four, 10/11 eight |
| code_tbl | input | 24 | Eight 3-bit code entries, entry 0 in bits 2:0 |
| sym_valid | output | 1 | Output symbol qualifier |
| sym_code | output | 3 | Coded hard-decision symbol |

## Verification
The assertions check four things on every cycle: the valid latency against a shadow pipe of the input qualifier, the zero symbol while idle, the range of the raw index for the two- and four-phase orders, and the forced index for an all-zero sample. Whether the sector picked for a given angle is the right one, whether the table lookup is correct, and whether order and table are captured per sample can only be shown by the bench's scenarios. The bench compares every symbol against an index it computes from a floating-point arctangent. It also changes the table and order right after a sample and resets the block in the middle of a stream.

// File: rtl/psk_dec_pkg.sv
package psk_dec_pkg;

  localparam int PH_W   = 16;
  localparam int SYM_W  = 3;
  localparam int N_ENT  = 8;
  localparam int MAP_W  = SYM_W * N_ENT;

  typedef enum logic [1:0] {
    ORD_TWO   = 2'b00,
    ORD_FOUR  = 2'b01,
    ORD_EIGHT = 2'b10,
    ORD_ALT8  = 2'b11
  } order_e;

  // Side information that travels down the pipe beside each sample.
  typedef struct packed {
    logic             vld;
    logic             zero;
    order_e           ord;
    logic [MAP_W-1:0] tbl;
  } side_t;

  // atan(2^-n) expressed in phase counts (65536 per turn).
  function automatic logic [PH_W-1:0] atan_step(input int n);
    case (n)
      0:  return 16'd8192;
      1:  return 16'd4836;
      2:  return 16'd2555;
      3:  return 16'd1297;
      4:  return 16'd651;
      5:  return 16'd326;
      6:  return 16'd163;
      7:  return 16'd81;
      8:  return 16'd41;
      9:  return 16'd20;
      10: return 16'd10;
      11: return 16'd5;
      12: return 16'd3;
      13: return 16'd1;
      default: return 16'd0;
    endcase
  endfunction

  // Half a sector in phase counts for the chosen order.
  function automatic logic [PH_W-1:0] half_sector(input order_e o);
    case (o)
      ORD_TWO:  return 16'h4000;
      ORD_FOUR: return 16'h2000;
      default:  return 16'h1000;
    endcase
  endfunction

  // Sector number: shift phase by half a sector, keep the top bits.
  function automatic logic [SYM_W-1:0] sector_of(input logic [PH_W-1:0] ph,
                                                 input order_e o);
    logic [PH_W-1:0] s;
    s = ph + half_sector(o);
    case (o)
      ORD_TWO:  return {2'b00, s[PH_W-1]};
      ORD_FOUR: return {1'b0, s[PH_W-1 -: 2]};
      default:  return s[PH_W-1 -: 3];
    endcase
  endfunction

  function automatic logic [SYM_W-1:0] code_of(input logic [MAP_W-1:0] tbl,
                                               input logic [SYM_W-1:0] idx);
    return tbl[SYM_W*idx +: SYM_W];
  endfunction

endpackage

// File: rtl/psk_cordic_entry.sv
module psk_cordic_entry
  import psk_dec_pkg::*;
#(
  parameter int DW = 16,
  parameter int XW = DW + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  input  logic [1:0]           in_ord,
  input  logic [MAP_W-1:0]     in_tbl,
  output logic signed [XW-1:0] x_o,
  output logic signed [XW-1:0] y_o,
  output logic [PH_W-1:0]      z_o,
  output side_t                sd_o
);

  logic signed [XW-1:0] xe, ye;
  logic                 left_half;
  logic                 is_zero;

  always_comb begin
    xe        = XW'(in_i);
    ye        = XW'(in_q);
    left_half = in_i[DW-1];
    is_zero   = (in_i == '0) && (in_q == '0);
  end

  // Fold the left half plane into the right by a half-turn rotation.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_o  <= '0;
      y_o  <= '0;
      z_o  <= '0;
      sd_o <= '0;
    end else begin
      x_o      <= left_half ? -xe : xe;
      y_o      <= left_half ? -ye : ye;
      z_o      <= left_half ? 16'h8000 : 16'h0000;
      sd_o.vld  <= in_vld;
      sd_o.zero <= is_zero;
      sd_o.ord  <= order_e'(in_ord);
      sd_o.tbl  <= in_tbl;
    end
  end

endmodule

// File: rtl/psk_cordic_stage.sv
module psk_cordic_stage
  import psk_dec_pkg::*;
#(
  parameter int XW    = 18,
  parameter int SHIFT = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [XW-1:0] x_i,
  input  logic signed [XW-1:0] y_i,
  input  logic [PH_W-1:0]      z_i,
  input  side_t                sd_i,
  output logic signed [XW-1:0] x_o,
  output logic signed [XW-1:0] y_o,
  output logic [PH_W-1:0]      z_o,
  output side_t                sd_o
);

  localparam logic [PH_W-1:0] STEP = atan_step(SHIFT);

  logic signed [XW-1:0] x_sh, y_sh, x_n, y_n;
  logic [PH_W-1:0]      z_n;

  always_comb begin
    x_sh = x_i >>> SHIFT;
    y_sh = y_i >>> SHIFT;
    if (!y_i[XW-1]) begin
      x_n = x_i + y_sh;
      y_n = y_i - x_sh;
      z_n = z_i + STEP;
    end else begin
      x_n = x_i - y_sh;
      y_n = y_i + x_sh;
      z_n = z_i - STEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_o  <= '0;
      y_o  <= '0;
      z_o  <= '0;
      sd_o <= '0;
    end else begin
      x_o  <= x_n;
      y_o  <= y_n;
      z_o  <= z_n;
      sd_o <= sd_i;
    end
  end

endmodule

// File: rtl/psk_sector_map.sv
module psk_sector_map
  import psk_dec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PH_W-1:0]  ph_i,
  input  side_t            sd_i,
  output logic             vld_o,
  output logic [SYM_W-1:0] sym_o,
  output logic [SYM_W-1:0] idx_o,
  output order_e           ord_o,
  output logic             zero_o
);

  logic [SYM_W-1:0] idx_c;

  always_comb begin
    idx_c = sd_i.zero ? '0 : sector_of(ph_i, sd_i.ord);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o  <= 1'b0;
      sym_o  <= '0;
      idx_o  <= '0;
      ord_o  <= ORD_TWO;
      zero_o <= 1'b0;
    end else begin
      vld_o  <= sd_i.vld;
      sym_o  <= sd_i.vld ? code_of(sd_i.tbl, idx_c) : '0;
      idx_o  <= idx_c;
      ord_o  <= sd_i.ord;
      zero_o <= sd_i.zero;
    end
  end

endmodule

// File: rtl/psk_sym_decide.sv
module psk_sym_decide
  import psk_dec_pkg::*;
#(
  parameter int DW   = 16,
  parameter int ITER = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_valid,
  input  logic signed [DW-1:0] smp_i,
  input  logic signed [DW-1:0] smp_q,
  input  logic [1:0]           mod_sel,
  input  logic [MAP_W-1:0]     code_tbl,
  output logic                 sym_valid,
  output logic [SYM_W-1:0]     sym_code
);

  localparam int XW = DW + 2;

  logic signed [XW-1:0] xs [0:ITER];
  logic signed [XW-1:0] ys [0:ITER];
  logic [PH_W-1:0]      zs [0:ITER];
  side_t                sds [0:ITER];

  // Named wires brought out for the bound checker.
  logic [SYM_W-1:0] dec_idx;
  order_e           dec_ord;
  logic             dec_zero;

  psk_cordic_entry #(.DW(DW), .XW(XW)) u_entry (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_vld (smp_valid),
    .in_i   (smp_i),
    .in_q   (smp_q),
    .in_ord (mod_sel),
    .in_tbl (code_tbl),
    .x_o    (xs[0]),
    .y_o    (ys[0]),
    .z_o    (zs[0]),
    .sd_o   (sds[0])
  );

  for (genvar g = 0; g < ITER; g++) begin : g_iter
    psk_cordic_stage #(.XW(XW), .SHIFT(g)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .x_i   (xs[g]),
      .y_i   (ys[g]),
      .z_i   (zs[g]),
      .sd_i  (sds[g]),
      .x_o   (xs[g+1]),
      .y_o   (ys[g+1]),
      .z_o   (zs[g+1]),
      .sd_o  (sds[g+1])
    );
  end

  // The residual vector of the final stage carries no decision content.
  logic unused_tail;
  assign unused_tail = ^{xs[ITER], ys[ITER]};

  psk_sector_map u_map (
    .clk    (clk),
    .rst_n  (rst_n),
    .ph_i   (zs[ITER]),
    .sd_i   (sds[ITER]),
    .vld_o  (sym_valid),
    .sym_o  (sym_code),
    .idx_o  (dec_idx),
    .ord_o  (dec_ord),
    .zero_o (dec_zero)
  );

endmodule

// File: rtl/psk_sym_decide_chk.sv
module psk_sym_decide_chk
  import psk_dec_pkg::*;
#(
  parameter int LAT = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_valid,
  input logic             sym_valid,
  input logic [SYM_W-1:0] sym_code,
  input logic [SYM_W-1:0] dec_idx,
  input order_e           dec_ord,
  input logic             dec_zero
);

  // Shadow of the input qualifier, LAT cycles deep.
  logic [LAT-1:0] vshadow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vshadow <= '0;
    else        vshadow <= {vshadow[LAT-2:0], smp_valid};
  end

  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid == vshadow[LAT-1]);

  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_valid |-> sym_code == '0);

  assert_two_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && dec_ord == ORD_TWO) |-> dec_idx < 3'd2);

  assert_four_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && dec_ord == ORD_FOUR) |-> dec_idx < 3'd4);

  assert_zero_index_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && dec_zero) |-> dec_idx == '0);

endmodule

bind psk_sym_decide psk_sym_decide_chk #(.LAT(ITER + 2)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_valid (smp_valid),
  .sym_valid (sym_valid),
  .sym_code  (sym_code),
  .dec_idx   (dec_idx),
  .dec_ord   (dec_ord),
  .dec_zero  (dec_zero)
);

// File: tb/test_psk_sym_decide.sv
module test_psk_sym_decide;

  localparam int  CLK_PERIOD = 10;
  localparam int  LAT        = 16;
  localparam real PI         = 3.14159265358979;

  localparam logic [23:0] TBL_A = {3'd2, 3'd7, 3'd4, 3'd1, 3'd6, 3'd3, 3'd0, 3'd5};
  localparam logic [23:0] TBL_B = {3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               smp_valid = 1'b0;
  logic signed [15:0] smp_i = '0;
  logic signed [15:0] smp_q = '0;
  logic [1:0]         mod_sel = '0;
  logic [23:0]        code_tbl = '0;
  logic               sym_valid;
  logic [2:0]         sym_code;

  typedef struct {
    logic [2:0] sym;
    int         due;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  psk_sym_decide i_psk_sym_decide (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_i     (smp_i),
    .smp_q     (smp_q),
    .mod_sel   (mod_sel),
    .code_tbl  (code_tbl),
    .sym_valid (sym_valid),
    .sym_code  (sym_code)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // Reference sector from a floating-point angle (R1..R5, R7).
  function automatic int ref_idx(input int si, input int sq, input int m);
    int  nsec;
    real ph;
    real w;
    int  k;
    nsec = (m == 0) ? 2 : (m == 1) ? 4 : 8;
    if (si == 0 && sq == 0) return 0;
    ph = $atan2(real'(sq), real'(si)) / (2.0 * PI) * 65536.0;
    if (ph < 0.0) ph = ph + 65536.0;
    w = 65536.0 / real'(nsec);
    k = int'($floor((ph + w / 2.0) / w));
    return k % nsec;
  endfunction

  // Driver: called at a falling edge; drives one sample for one cycle.
  task automatic send(input int si, input int sq, input logic [1:0] m,
                      input logic [23:0] tbl, input string req);
    exp_t e;
    int   idx;
    idx       = ref_idx(si, sq, int'(m));
    smp_valid = 1'b1;
    smp_i     = 16'(si);
    smp_q     = 16'(sq);
    mod_sel   = m;
    code_tbl  = tbl;
    e.sym     = tbl[3*idx +: 3];
    e.due     = cyc + LAT;
    e.req     = req;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    smp_valid = 1'b0;
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // Monitor: pops and compares as results come out (R6, R8, R9).
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (sym_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R11 unexpected symbol", int'(sym_code), -1);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(sym_code == e.sym, {e.req, " R6 symbol"}, int'(sym_code), int'(e.sym));
          chk(cyc == e.due, {e.req, " R8 latency"}, cyc, e.due);
        end
      end else if (sym_code != 3'd0) begin
        chk(1'b0, "R9 idle symbol", int'(sym_code), 0);
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    real amps[2];
    real fr[3];
    amps[0] = 20000.0; amps[1] = 300.0;
    fr[0] = -0.6; fr[1] = 0.0; fr[2] = 0.55;

    repeat (3) @(negedge clk);
    chk(sym_valid == 1'b0, "R11 reset valid", int'(sym_valid), 0);
    chk(sym_code == 3'd0, "R11 reset symbol", int'(sym_code), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5: sweep sector centres and interiors, back to back.
    for (int m = 0; m < 4; m++) begin
      int nsec;
      nsec = (m == 0) ? 2 : (m == 1) ? 4 : 8;
      for (int a = 0; a < 2; a++) begin
        for (int k = 0; k < nsec; k++) begin
          for (int f = 0; f < 3; f++) begin
            real ang;
            int  si, sq;
            string rq;
            ang = real'(k) * 2.0 * PI / real'(nsec) + fr[f] * PI / real'(nsec);
            si  = int'(amps[a] * $cos(ang));
            sq  = int'(amps[a] * $sin(ang));
            rq  = (m == 0) ? "R2" : (m == 1) ? "R3" : (m == 2) ? "R4" : "R5";
            send(si, sq, 2'(m), (k % 2 == 0) ? TBL_A : TBL_B, rq);
          end
        end
        idle(a + 1);
      end
    end

    // R7: all-zero input in every order.
    for (int m = 0; m < 4; m++) send(0, 0, 2'(m), TBL_A, "R7");
    idle(2);

    // R1: full-scale corners.
    send(-32768, 0, 2'b10, TBL_A, "R1");
    send(-32768, 0, 2'b01, TBL_A, "R1");
    send(-32768, 0, 2'b00, TBL_A, "R1");
    send(-32768, -32768, 2'b10, TBL_A, "R1");
    send(32767, 32767, 2'b10, TBL_B, "R1");
    send(0, -32768, 2'b01, TBL_A, "R1");
    send(1, 0, 2'b10, TBL_A, "R1");
    send(0, 1, 2'b11, TBL_A, "R1");

    // R10: order and table change right after capture, without valid.
    send(0, 20000, 2'b01, TBL_A, "R10");
    smp_valid = 1'b0;
    mod_sel   = 2'b10;
    code_tbl  = TBL_B;
    smp_i     = 16'sd0;
    smp_q     = -16'sd20000;
    repeat (5) @(negedge clk);
    send(-14142, 14142, 2'b10, TBL_B, "R10");
    mod_sel  = 2'b00;
    code_tbl = TBL_A;
    idle(LAT + 4);
    chk(exp_q.size() == 0, "R8 drain", exp_q.size(), 0);

    // R11: reset with samples in flight; nothing stale may follow.
    send(20000, 0, 2'b10, TBL_A, "R11");
    send(0, 20000, 2'b10, TBL_A, "R11");
    send(-20000, 0, 2'b10, TBL_A, "R11");
    smp_valid = 1'b0;
    rst_n     = 1'b0;
    exp_q.delete();
    @(negedge clk);
    chk(sym_valid == 1'b0, "R11 valid in reset", int'(sym_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(LAT + 4);
    send(14142, -14142, 2'b10, TBL_B, "R11");
    idle(LAT + 4);
    chk(exp_q.size() == 0, "R11 drain", exp_q.size(), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule